// File: doc/BRIEF.md
# Trace port capture FIFO

This block samples a 32-bit trace data bus on every rising edge of the system clock. A qualifier decides whether the word is kept. Kept words go into a small first-in first-out store. Software or a DMA channel drains the store through a readable data register. A DMA request output tells the channel when the store holds data.

A control register has two bits. The hold bit keeps the store empty for as long as it is set. The drop flag records that a qualified word was lost because the store was full. Capture begins when software clears the hold bit. Software sets the hold bit again once its buffer is full.

The register port is a simple single-cycle interface. Read data is combinational and follows the address in the same cycle. A read of the data register pops the oldest entry at the next clock edge.

Top module: `trace_capture_fifo`

## Requirements
- R1: After reset, the control register at address 0x0 reads 0x1: bit 0 (hold) is 1 and bit 1 (drop flag) is 0. The DMA request is low.
- R2: While hold is 0, a rising clock edge with `trc_ctl` low pushes the whole 32-bit `trc_data` word unchanged. The store keeps up to DEPTH (8) words in arrival order.
- R3: With `trc_ctl` high, a word is pushed only when `trc_data[1:0]` is 2'b00. Any other value of those two bits pushes nothing.
- R4: A qualified word that arrives while the store is full, with no pop in the same cycle, is discarded. The drop flag (bit 1) is then set and the stored words are unchanged.
- R5: The drop flag stays set until a write to 0x0 has bit 1 equal to 1. Writing 0 to bit 1 leaves the flag as it is. If a new drop happens in the same cycle as a clear, the flag stays set.
- R6: A write to 0x0 loads bit 0 into hold. A write of 1 empties the store at that edge and captures nothing in that cycle. While hold is 1, the store stays empty and no drop can be flagged.
- R7: A read at 0x0 returns {30'b0, drop, hold}. A read at 0x4 returns the oldest word in the store and removes it at the clock edge.
- R8: A read at 0x4 while the store is empty returns 0 and leaves the store unchanged.
- R9: When the store is full and a pop and a qualified push happen in the same cycle, both are accepted. The store stays full and no drop is flagged.
- R10: `dma_req` is high exactly when the store is non-empty and hold is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trc_ctl | input | 1 | Trace control qualifier |
| trc_data | input | 32 | Trace data bus |
| reg_addr | input | 3 | Byte address of the register access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| dma_req | output | 1 | Request for the data register to be read |

## Verification
Some properties are checked on every cycle:
- The occupancy never exceeds the depth.
- The drop flag rises only when the store was full.
- The drop flag never falls without a clearing write.
- Hold implies an empty store.
- An empty data read returns zero.
- A full store with a pop and a push in the same cycle stays full.

Other behaviour can only be shown by the bench's scenarios, which compare each output against a reference queue model:
- Arrival order and whole-word integrity.
- The trigger-packet qualification.
- The write-zero case.
- The order in which same-cycle set and clear are resolved.

// File: rtl/trace_capture_fifo.sv
module trace_capture_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trc_ctl,
  input  logic [DW-1:0] trc_data,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          dma_req
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          hold, drop;

  wire sel_ctl  = (reg_addr == 3'd0);
  wire sel_data = (reg_addr == 3'd4);
  wire ctl_wr   = reg_wr && sel_ctl;
  wire clr      = hold || (ctl_wr && reg_wdata[0]);
  wire empty    = (count == '0);
  wire full     = (count == CW'(DEPTH));
  wire qual     = !trc_ctl || (trc_data[1:0] == 2'b00);
  wire push_try = !clr && qual;
  wire pop      = reg_rd && sel_data && !empty && !hold;
  wire push     = push_try && (!full || pop);
  wire lost     = push_try && full && !pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= trc_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= nxt(wptr);
      if (pop)  rptr <= nxt(rptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b1;
      drop <= 1'b0;
    end else begin
      if (ctl_wr) hold <= reg_wdata[0];
      if (lost) drop <= 1'b1;
      else if (ctl_wr && reg_wdata[1]) drop <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_ctl) reg_rdata = {{(DW-2){1'b0}}, drop, hold};
    else if (sel_data && !empty && !hold) reg_rdata = mem[rptr];
  end

  assign dma_req = !empty && !hold;

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r4_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drop) |-> $past(count) == CW'(DEPTH));
  a_r5_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drop) |-> $past(reg_wr && reg_addr == 3'd0 && reg_wdata[1]));
  a_r6_hold_empty: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> count == '0);
  a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd4 && count == '0) |-> reg_rdata == '0);
  a_r9_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pop && push_try) |=> count == CW'(DEPTH));
endmodule

// File: tb/tb_trace_capture_fifo.sv
`timescale 1ns/1ps
module tb_trace_capture_fifo;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        trc_ctl = 1;
  logic [31:0] trc_data = '1;
  logic [2:0]  reg_addr = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        dma_req;

  trace_capture_fifo dut (.*);

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] q [8];
  int qn = 0;
  bit m_hold = 1, m_drop = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata(logic [2:0] a);
    if (a == 3'd0) return {30'b0, m_drop, m_hold};
    if (a == 3'd4 && qn > 0 && !m_hold) return q[0];
    return 32'h0;
  endfunction

  task automatic step(string tag, bit ctl, logic [31:0] d, bit wr, bit rd,
                      logic [2:0] a, logic [31:0] wd);
    bit clr, ptry, pop, lost;
    @(negedge clk);
    trc_ctl = ctl; trc_data = d; reg_wr = wr; reg_rd = rd;
    reg_addr = a; reg_wdata = wd;
    #1;
    if (rd) chk(tag, reg_rdata, exp_rdata(a));
    chk({tag, " dma_req (R10)"}, {31'b0, dma_req}, {31'b0, (qn > 0 && !m_hold)});
    @(posedge clk);
    clr  = m_hold || (wr && a == 0 && wd[0]);
    ptry = !clr && (!ctl || d[1:0] == 2'b00);
    pop  = rd && a == 4 && qn > 0 && !m_hold;
    lost = ptry && qn == 8 && !pop;
    if (lost) m_drop = 1;
    else if (wr && a == 0 && wd[1]) m_drop = 0;
    if (clr) qn = 0;
    else begin
      if (pop) begin
        for (int i = 0; i < 7; i++) q[i] = q[i+1];
        qn--;
      end
      if (ptry && qn < 8) begin q[qn] = d; qn++; end
    end
    if (wr && a == 0) m_hold = wd[0];
  endtask

  task automatic idle(string tag); step(tag, 1, 32'h3, 0, 0, 0, 0); endtask
  task automatic push(string tag, bit ctl, logic [31:0] d); step(tag, ctl, d, 0, 0, 0, 0); endtask
  task automatic rd_data(string tag); step(tag, 1, 32'h1, 0, 1, 4, 0); endtask
  task automatic rd_ctl(string tag); step(tag, 1, 32'h1, 0, 1, 0, 0); endtask
  task automatic wr_ctl(string tag, logic [31:0] v); step(tag, 1, 32'h1, 1, 0, 0, v); endtask

  initial begin
    #200000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    #9 rst_n = 1;
    rd_ctl("R1 reset ctrl");
    idle("R1 reset dma");
    for (int i = 0; i < 5; i++) push("R6 hold no capture", 0, 32'hA0 + i);
    rd_data("R6 hold read");
    rd_ctl("R6 hold ctrl");
    wr_ctl("R6 start", 0);
    push("R2 normal", 0, 32'hDEAD_BEEF);
    push("R2 normal", 0, 32'h1234_5677);
    push("R3 trigger", 1, 32'hCAFE_0000);
    push("R3 reject 01", 1, 32'hFFFF_FFFD);
    push("R3 reject 10", 1, 32'hFFFF_FFFE);
    idle("R10 nonempty");
    rd_data("R7 pop 1"); rd_data("R7 pop 2"); rd_data("R3 trigger pop");
    rd_data("R8 empty read");
    idle("R10 empty");
    for (int i = 0; i < 8; i++) push("R2 fill", 0, 32'h100 + i);
    push("R4 overflow", 0, 32'hBAD0_0000);
    rd_ctl("R4 flag set");
    wr_ctl("R5 write 0 keeps", 0);
    rd_ctl("R5 still set");
    wr_ctl("R5 clear", 2);
    rd_ctl("R5 cleared");
    step("R9 full swap", 0, 32'h5555_AAA8, 0, 1, 4, 0);
    rd_ctl("R9 no drop");
    step("R5 set beats clear", 0, 32'h7777_0000, 1, 0, 0, 2);
    rd_ctl("R5 set wins");
    rd_data("R9 order");
    wr_ctl("R6 flush", 3);
    idle("R6 flushed dma");
    rd_data("R6 flushed read");
    wr_ctl("R6 restart", 0);
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      bit ctl = ($urandom_range(0, 3) == 0);
      logic [31:0] d = $urandom;
      if (r < 35)      step("R2 rand pop", ctl, d, 0, 1, 4, 0);
      else if (r < 38) step("R7 rand ctrl", ctl, d, 0, 1, 0, 0);
      else if (r < 40) step("R5 rand clear", ctl, d, 1, 0, 0, 2);
      else if (r < 41) step("R6 rand flush", ctl, d, 1, 0, 0, 1);
      else if (r < 43) step("R6 rand start", ctl, d, 1, 0, 0, 0);
      else             step("R3 rand push", ctl, d, 0, 0, 0, 0);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule